// File: doc/BRIEF.md
# Processor Exception Entry Unit

This unit moves a 64-bit processor into an exception handler. On a one-cycle strobe it takes an exception code, a two-bit subcause, the current program counter and the current machine status word. From these and a set of configuration inputs it builds the saved-state pair, the status word the handler runs with, and the handler address. The configuration inputs are a per-code vector table, a global vector prefix, a two-bit relocation mode, an implemented-bit mask and a power-save flag. Events that cannot be delivered drive a sticky checkstop output instead.

The unit keeps two saved pairs, each holding a PC and a status word. The ordinary pair serves most events. The hypervisor pair serves the hypervisor-class events. A return request restores the PC and status word from either pair. On return the status word is sanitised and the PC is aligned and, in 32-bit mode, truncated.

Exception codes: 0 reset, 1 machine check, 2 external, 3 program, 4 system call, 5 decrementer, 6 doorbell, 7 hypervisor doorbell, 8 hypervisor maintenance, 9 hypervisor decrementer. Codes 10 to 15 are invalid and cause a checkstop.

Top module: `exc_entry_unit`

## Requirements
- R1: A taken event saves the current status word with bits 30:27 and 21:16 forced to zero (cause bits are then ORed in). The saved PC is the current PC, except for a system call (code 4), which saves PC+4.
- R2: The new status word starts from the current one with only machine-check-enable (bit 12) and hypervisor (bit 60) kept, all other bits clear. The final value is ANDed with the implemented-bit mask.
- R3: A program exception (code 3) ORs one saved-status bit chosen by the subcause: 0 floating-point enabled sets bit 20, 1 illegal instruction sets bit 19, 2 privileged sets bit 18, 3 trap sets bit 17.
- R4: A floating-point program exception (code 3, subcause 0) is dropped with no output or state change when the FP-available bit (13) is 0, or when both FP mode bits (11 and 8) are 0.
- R5: A machine check (code 1) clears machine-check-enable in the new status word and sets hypervisor when the mask implements bit 60. A machine check arriving while bit 12 of the current status is 0 raises checkstop instead.
- R6: With the power-save flag set, every event except a machine check goes to the reset vector. The saved status gets bit 16 plus a wake cause in bits 21:18: reset 4, external 8, decrementer 6, doorbell 5, hypervisor doorbell 3, hypervisor maintenance 0xA. Any other event in power save raises checkstop.
- R7: A reset (code 0) taken with the power-management bit (18) set in the current status sets saved bit 16 and sets machine-check-enable in the new status word. A reset also sets hypervisor when the mask implements bit 60.
- R8: The handler address is the vector-table entry for the code ORed with the prefix. An all-ones entry or an invalid code raises checkstop.
- R9: Relocation applies only when all of the following hold: the event is not a reset or machine check, the old status has both translation bits set (instruction bit 5, data bit 4), and the event does not newly enter hypervisor state. When it applies, mode 2 ORs 0x18000 into the handler address, mode 3 ORs 0xC000000000004000, and the new status word gets bits 5 and 4 set. Modes 0 and 1 never relocate.
- R10: Hypervisor-class events (codes 7, 8, 9, outside power save) write the hypervisor pair, flag it on `enter_hv`, set hypervisor in the new status word and copy the recoverable bit (1) from the current status.
- R11: A return (`rfi_req`, with `rfi_hv` selecting the pair) outputs the saved status with bit 18 cleared and ANDed with the mask. It outputs the saved PC with its low two bits cleared, and with its upper 32 bits cleared when the returned bit 63 is 0.
- R12: Outputs update on the clock edge after the strobe. `enter_valid` and `ret_valid` are one-cycle pulses. An exception has priority over a return in the same cycle. Checkstop stays high until reset, and while it is high all events and returns are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_code | input | 4 | Exception code |
| exc_sub | input | 2 | Program-exception subcause |
| cur_pc | input | 64 | PC of the faulting or interrupted instruction |
| cur_msr | input | 64 | Current machine status word |
| vec_table | input | 640 | Vector table, entry i in bits i*64 +: 64 |
| vec_prefix | input | 64 | Global handler prefix |
| reloc_mode | input | 2 | Handler relocation mode |
| impl_mask | input | 64 | Implemented status bits |
| pwr_save | input | 1 | Core is in a power-save state |
| rfi_req | input | 1 | One-cycle return request |
| rfi_hv | input | 1 | Return from the hypervisor pair |
| enter_valid | output | 1 | Handler entry pulse |
| enter_hv | output | 1 | Last entry used the hypervisor pair |
| handler_pc | output | 64 | Handler address |
| new_msr | output | 64 | Status word for the handler |
| srr_pc | output | 64 | Ordinary saved PC |
| srr_msr | output | 64 | Ordinary saved status |
| hsrr_pc | output | 64 | Hypervisor saved PC |
| hsrr_msr | output | 64 | Hypervisor saved status |
| checkstop | output | 1 | Sticky checkstop |
| ret_valid | output | 1 | Return pulse |
| ret_pc | output | 64 | Return PC |
| ret_msr | output | 64 | Return status word |

## Verification
The bench first drives all-ones and all-zero status words. This separates the save mask and the carry-over bits from stray bits copied from the input. Each program subcause and each wake cause is driven with otherwise equal inputs, so a swapped bit or code shows up as a different saved status. Relocation is tried across all the factors that gate it: both modes, one translation bit missing, entering hypervisor versus already in it, and the reset code. The return path uses one PC above 4 GB and one PC with unaligned low bits, under both settings of bit 63, so truncation is told apart from alignment.

// File: rtl/exc_entry_pkg.sv
// Shared encodings for the exception entry unit.
// Assumes a 64-bit status word with bit 0 as least significant.
package exc_entry_pkg;
    localparam int XLEN    = 64;
    localparam int CODE_W  = 4;
    localparam int SUB_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        EC_RESET   = 4'd0,
        EC_MCHECK  = 4'd1,
        EC_EXT     = 4'd2,
        EC_PROG    = 4'd3,
        EC_SYSCALL = 4'd4,
        EC_DECR    = 4'd5,
        EC_DBELL   = 4'd6,
        EC_HDBELL  = 4'd7,
        EC_HMAINT  = 4'd8,
        EC_HDECR   = 4'd9
    } exc_code_e;

    localparam int B_RI  = 1;
    localparam int B_DR  = 4;
    localparam int B_IR  = 5;
    localparam int B_FE1 = 8;
    localparam int B_FE0 = 11;
    localparam int B_ME  = 12;
    localparam int B_FP  = 13;
    localparam int B_POW = 18;
    localparam int B_HV  = 60;
    localparam int B_SF  = 63;

    localparam logic [XLEN-1:0] SAVE_CLEAR = 64'h0000_0000_783F_0000;
    localparam logic [XLEN-1:0] RELOC_LOW  = 64'h0000_0000_0001_8000;
    localparam logic [XLEN-1:0] RELOC_HIGH = 64'hC000_0000_0000_4000;

    typedef struct packed {
        logic              stop;
        logic              drop;
        logic              hv;
        logic              reloc_ok;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   save_pc;
        logic [XLEN-1:0]   save_msr;
        logic [XLEN-1:0]   new_pre;
    } dec_t;
endpackage

// File: rtl/exc_decode.sv
// Classifies one event: applies the power-save redirect, builds the
// saved pair and the unmasked new status word, and flags stop or drop.
// Assumes a purely combinational path; registering is done by the top.
module exc_decode
    import exc_entry_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [SUB_W-1:0]  sub,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   msr,
    input  logic              impl_hv,
    input  logic              pwr_save,
    output dec_t              dec
);
    exc_code_e  eff;
    logic [3:0] wake;
    logic       unsup;
    logic       redirect;

    // Redirect power-save wakeups to reset and pick the wake cause.
    always_comb begin
        redirect = pwr_save && (code != 4'(EC_MCHECK));
        eff      = redirect ? EC_RESET : exc_code_e'(code);
        wake     = 4'h0;
        unsup    = 1'b0;
        if (redirect) begin
            case (exc_code_e'(code))
                EC_RESET:  wake = 4'h4;
                EC_EXT:    wake = 4'h8;
                EC_DECR:   wake = 4'h6;
                EC_DBELL:  wake = 4'h5;
                EC_HDBELL: wake = 4'h3;
                EC_HMAINT: wake = 4'hA;
                default:   unsup = 1'b1;
            endcase
        end
    end

    // Per-class rules for the saved pair and the new status word.
    always_comb begin
        dec          = '0;
        dec.code     = eff;
        dec.stop     = unsup;
        dec.reloc_ok = 1'b1;
        dec.save_pc  = pc;
        dec.save_msr = msr & ~SAVE_CLEAR;
        dec.new_pre  = '0;
        dec.new_pre[B_ME] = msr[B_ME];
        dec.new_pre[B_HV] = msr[B_HV];
        if (redirect) begin
            dec.save_msr[16] = 1'b1;
            dec.save_msr = dec.save_msr | ({{(XLEN-4){1'b0}}, wake} << 18);
        end
        case (eff)
            EC_RESET: begin
                if (msr[B_POW]) begin
                    dec.save_msr[16]  = 1'b1;
                    dec.new_pre[B_ME] = 1'b1;
                end
                if (impl_hv) dec.new_pre[B_HV] = 1'b1;
                dec.reloc_ok = 1'b0;
            end
            EC_MCHECK: begin
                if (!msr[B_ME]) dec.stop = 1'b1;
                if (impl_hv) dec.new_pre[B_HV] = 1'b1;
                dec.new_pre[B_ME] = 1'b0;
                dec.reloc_ok = 1'b0;
            end
            EC_PROG: begin
                case (sub)
                    2'd0: begin
                        if (!msr[B_FP] || (!msr[B_FE0] && !msr[B_FE1]))
                            dec.drop = 1'b1;
                        dec.save_msr[20] = 1'b1;
                    end
                    2'd1:    dec.save_msr[19] = 1'b1;
                    2'd2:    dec.save_msr[18] = 1'b1;
                    default: dec.save_msr[17] = 1'b1;
                endcase
            end
            EC_SYSCALL: dec.save_pc = pc + 64'd4;
            EC_EXT, EC_DECR, EC_DBELL: ;
            EC_HDBELL, EC_HMAINT, EC_HDECR: begin
                dec.hv            = 1'b1;
                dec.new_pre[B_HV] = 1'b1;
                dec.new_pre[B_RI] = msr[B_RI];
            end
            default: dec.stop = 1'b1;
        endcase
    end
endmodule

// File: rtl/exc_vector.sv
// Looks up the handler address, applies the prefix and the conditional
// relocation, and produces the final masked status word.
// Assumes NUM_CODES table entries of XLEN bits, entry i at i*XLEN.
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter int NUM_CODES = 10
) (
    input  logic [CODE_W-1:0]         code,
    input  logic [NUM_CODES*XLEN-1:0] vec_table,
    input  logic [XLEN-1:0]           vec_prefix,
    input  logic [1:0]                reloc_mode,
    input  logic                      reloc_ok,
    input  logic                      old_ir,
    input  logic                      old_dr,
    input  logic                      old_hv,
    input  logic [XLEN-1:0]           new_pre,
    input  logic [XLEN-1:0]           impl_mask,
    output logic [XLEN-1:0]           handler,
    output logic [XLEN-1:0]           new_msr,
    output logic                      undef
);
    logic [XLEN-1:0] tbl [NUM_CODES];
    logic [XLEN-1:0] entry;
    logic            apply;
    logic [XLEN-1:0] relocated;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
        assign tbl[g] = vec_table[g*XLEN +: XLEN];
    end

    // Select the entry; out-of-range codes read as undefined.
    always_comb begin
        entry = '1;
        if (int'(code) < NUM_CODES) entry = tbl[code];
    end

    // Relocation only without a new hypervisor entry and with translation on.
    always_comb begin
        undef     = (entry == '1);
        apply     = reloc_ok && reloc_mode[1] && old_ir && old_dr &&
                    !(new_pre[B_HV] && !old_hv);
        relocated = entry | vec_prefix;
        new_msr   = new_pre;
        if (apply) begin
            relocated    = relocated | (reloc_mode[0] ? RELOC_HIGH : RELOC_LOW);
            new_msr[B_IR] = 1'b1;
            new_msr[B_DR] = 1'b1;
        end
        new_msr = new_msr & impl_mask;
        handler = relocated;
    end
endmodule

// File: rtl/exc_return.sv
// Builds the return PC and status word from one saved pair.
// Assumes the caller selects the pair; purely combinational.
module exc_return
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] pair_pc,
    input  logic [XLEN-1:0] pair_msr,
    input  logic [XLEN-1:0] impl_mask,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] msr_out
);
    // Sanitise the status word, align and size the PC.
    always_comb begin
        msr_out        = pair_msr & impl_mask;
        msr_out[B_POW] = 1'b0;
        pc_out         = {pair_pc[XLEN-1:2], 2'b00};
        if (!msr_out[B_SF]) pc_out[XLEN-1:32] = '0;
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry unit top: registers handler entry, the two saved pairs,
// the return result and the sticky checkstop.
// Assumes exc_valid and rfi_req are single-cycle strobes.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int NUM_CODES = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exc_valid,
    input  logic [CODE_W-1:0]         exc_code,
    input  logic [SUB_W-1:0]          exc_sub,
    input  logic [XLEN-1:0]           cur_pc,
    input  logic [XLEN-1:0]           cur_msr,
    input  logic [NUM_CODES*XLEN-1:0] vec_table,
    input  logic [XLEN-1:0]           vec_prefix,
    input  logic [1:0]                reloc_mode,
    input  logic [XLEN-1:0]           impl_mask,
    input  logic                      pwr_save,
    input  logic                      rfi_req,
    input  logic                      rfi_hv,
    output logic                      enter_valid,
    output logic                      enter_hv,
    output logic [XLEN-1:0]           handler_pc,
    output logic [XLEN-1:0]           new_msr,
    output logic [XLEN-1:0]           srr_pc,
    output logic [XLEN-1:0]           srr_msr,
    output logic [XLEN-1:0]           hsrr_pc,
    output logic [XLEN-1:0]           hsrr_msr,
    output logic                      checkstop,
    output logic                      ret_valid,
    output logic [XLEN-1:0]           ret_pc,
    output logic [XLEN-1:0]           ret_msr
);
    dec_t            dec;
    logic [XLEN-1:0] handler_c;
    logic [XLEN-1:0] new_msr_c;
    logic            undef_c;
    logic [XLEN-1:0] rpc_c;
    logic [XLEN-1:0] rmsr_c;

    exc_decode u_dec (
        .code     (exc_code),
        .sub      (exc_sub),
        .pc       (cur_pc),
        .msr      (cur_msr),
        .impl_hv  (impl_mask[B_HV]),
        .pwr_save (pwr_save),
        .dec      (dec)
    );

    exc_vector #(.NUM_CODES(NUM_CODES)) u_vec (
        .code       (dec.code),
        .vec_table  (vec_table),
        .vec_prefix (vec_prefix),
        .reloc_mode (reloc_mode),
        .reloc_ok   (dec.reloc_ok),
        .old_ir     (cur_msr[B_IR]),
        .old_dr     (cur_msr[B_DR]),
        .old_hv     (cur_msr[B_HV]),
        .new_pre    (dec.new_pre),
        .impl_mask  (impl_mask),
        .handler    (handler_c),
        .new_msr    (new_msr_c),
        .undef      (undef_c)
    );

    exc_return u_ret (
        .pair_pc   (rfi_hv ? hsrr_pc  : srr_pc),
        .pair_msr  (rfi_hv ? hsrr_msr : srr_msr),
        .impl_mask (impl_mask),
        .pc_out    (rpc_c),
        .msr_out   (rmsr_c)
    );

    // Commit an entry, a return or a checkstop on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enter_valid <= 1'b0;
            enter_hv    <= 1'b0;
            handler_pc  <= '0;
            new_msr     <= '0;
            srr_pc      <= '0;
            srr_msr     <= '0;
            hsrr_pc     <= '0;
            hsrr_msr    <= '0;
            checkstop   <= 1'b0;
            ret_valid   <= 1'b0;
            ret_pc      <= '0;
            ret_msr     <= '0;
        end else begin
            enter_valid <= 1'b0;
            ret_valid   <= 1'b0;
            if (!checkstop) begin
                if (exc_valid) begin
                    if (dec.stop) begin
                        checkstop <= 1'b1;
                    end else if (!dec.drop) begin
                        if (undef_c) begin
                            checkstop <= 1'b1;
                        end else begin
                            enter_valid <= 1'b1;
                            enter_hv    <= dec.hv;
                            handler_pc  <= handler_c;
                            new_msr     <= new_msr_c;
                            if (dec.hv) begin
                                hsrr_pc  <= dec.save_pc;
                                hsrr_msr <= dec.save_msr;
                            end else begin
                                srr_pc   <= dec.save_pc;
                                srr_msr  <= dec.save_msr;
                            end
                        end
                    end
                end else if (rfi_req) begin
                    ret_valid <= 1'b1;
                    ret_pc    <= rpc_c;
                    ret_msr   <= rmsr_c;
                end
            end
        end
    end

    // Checkstop never clears without reset.
    p_stop_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);
    // An entry pulse always follows a strobe.
    p_enter_follows_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        enter_valid |-> $past(exc_valid));
    // Entry and return never fire together.
    p_entry_over_return_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(enter_valid && ret_valid));
    // A taken machine check runs without machine-check-enable.
    p_mcheck_no_me_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid && $past(exc_code) == 4'(EC_MCHECK)) |-> !new_msr[B_ME]);
    // The prefix bits always appear in the handler address.
    p_prefix_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enter_valid |-> ((handler_pc & $past(vec_prefix)) == $past(vec_prefix)));
    // Bits 30:27 of the ordinary saved status stay clear after an entry.
    p_save_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid && !enter_hv) |-> (srr_msr[30:27] == 4'h0));
    // Returned PC is aligned and the power bit is clear.
    p_ret_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_pc[1:0] == 2'b00 && !ret_msr[B_POW]));
endmodule

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              exc_valid = 1'b0;
    logic [3:0]        exc_code = '0;
    logic [1:0]        exc_sub = '0;
    logic [63:0]       cur_pc = '0;
    logic [63:0]       cur_msr = '0;
    logic [639:0]      vec_table;
    logic [63:0]       vec_prefix = '0;
    logic [1:0]        reloc_mode = '0;
    logic [63:0]       impl_mask = '1;
    logic              pwr_save = 1'b0;
    logic              rfi_req = 1'b0;
    logic              rfi_hv = 1'b0;
    logic              enter_valid, enter_hv, checkstop, ret_valid;
    logic [63:0]       handler_pc, new_msr, srr_pc, srr_msr, hsrr_pc, hsrr_msr;
    logic [63:0]       ret_pc, ret_msr;
    int                errors = 0;
    int                checks = 0;

    localparam logic [63:0] HV = 64'h1000_0000_0000_0000;
    localparam logic [63:0] ME = 64'h1000;

    always #2 clk = ~clk;

    exc_entry_unit u0 (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic fire(input logic [3:0] c, input logic [1:0] s,
                        input logic [63:0] pc, input logic [63:0] msr);
        @(negedge clk);
        exc_code = c; exc_sub = s; cur_pc = pc; cur_msr = msr; exc_valid = 1'b1;
        @(posedge clk); #1;
        exc_valid = 1'b0;
    endtask

    task automatic ret(input logic hv);
        @(negedge clk);
        rfi_hv = hv; rfi_req = 1'b1;
        @(posedge clk); #1;
        rfi_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset enter_valid", 64'(enter_valid), 0);
        chk("R12 reset checkstop", 64'(checkstop), 0);
        chk("R12 reset srr_pc", srr_pc, 0);
        chk("R12 reset ret_valid", 64'(ret_valid), 0);
    endtask

    task automatic t_basic();
        fire(4'd2, 2'd0, 64'h1000, '1);
        chk("R12 enter pulse", 64'(enter_valid), 1);
        chk("R1 saved pc", srr_pc, 64'h1000);
        chk("R1 saved msr mask", srr_msr, 64'hFFFF_FFFF_87C0_FFFF);
        chk("R2 new msr carry", new_msr, HV | ME);
        chk("R8 handler", handler_pc, 64'h300);
        @(posedge clk); #1;
        chk("R12 pulse one cycle", 64'(enter_valid), 0);
        fire(4'd4, 2'd0, 64'h2000, 64'h0);
        chk("R1 syscall pc+4", srr_pc, 64'h2004);
        chk("R2 new msr clear", new_msr, 0);
    endtask

    task automatic t_program();
        fire(4'd3, 2'd1, 64'h10, 0); chk("R3 illegal", srr_msr, 64'h80000);
        fire(4'd3, 2'd2, 64'h10, 0); chk("R3 privileged", srr_msr, 64'h40000);
        fire(4'd3, 2'd3, 64'h10, 0); chk("R3 trap", srr_msr, 64'h20000);
        fire(4'd3, 2'd0, 64'h10, 64'h2800); chk("R3 fp enabled", srr_msr, 64'h102800);
    endtask

    task automatic t_fp_drop();
        fire(4'd2, 2'd0, 64'h3000, 0);
        fire(4'd3, 2'd0, 64'h4000, 64'h2000);
        chk("R4 drop no FE enter", 64'(enter_valid), 0);
        chk("R4 drop no FE srr", srr_pc, 64'h3000);
        fire(4'd3, 2'd0, 64'h4000, 64'h0100);
        chk("R4 drop no FP enter", 64'(enter_valid), 0);
        chk("R4 drop no FP stop", 64'(checkstop), 0);
    endtask

    task automatic t_mcheck();
        fire(4'd1, 2'd0, 64'h50, ME);
        chk("R5 mcheck new msr", new_msr, HV);
        chk("R5 mcheck handler", handler_pc, 64'h200);
        impl_mask = ~HV;
        fire(4'd1, 2'd0, 64'h50, ME);
        chk("R5 mcheck no hv impl", new_msr, 0);
        impl_mask = '1;
        fire(4'd1, 2'd0, 64'h50, 0);
        chk("R5 mcheck me=0 stop", 64'(checkstop), 1);
        fire(4'd2, 2'd0, 64'h60, 0);
        chk("R12 ignored in checkstop", 64'(enter_valid), 0);
        chk("R12 checkstop sticky", 64'(checkstop), 1);
        ret(1'b0);
        chk("R12 return ignored in checkstop", 64'(ret_valid), 0);
        do_reset();
    endtask

    task automatic t_wake();
        pwr_save = 1'b1;
        fire(4'd2, 2'd0, 64'h70, 0);
        chk("R6 wake external", srr_msr, 64'h210000);
        chk("R6 wake to reset vector", handler_pc, 64'h100);
        chk("R6 wake new msr", new_msr, HV);
        fire(4'd5, 2'd0, 64'h70, 0); chk("R6 wake decrementer", srr_msr, 64'h190000);
        fire(4'd7, 2'd0, 64'h70, 0); chk("R6 wake hv doorbell", srr_msr, 64'hD0000);
        chk("R6 wake uses normal pair", 64'(enter_hv), 0);
        fire(4'd8, 2'd0, 64'h70, 0); chk("R6 wake hv maint", srr_msr, 64'h290000);
        fire(4'd1, 2'd0, 64'h70, ME);
        chk("R6 mcheck not redirected", handler_pc, 64'h200);
        chk("R6 mcheck no wake bits", srr_msr, ME);
        fire(4'd3, 2'd1, 64'h70, 0);
        chk("R6 unsupported wake stop", 64'(checkstop), 1);
        pwr_save = 1'b0;
        do_reset();
    endtask

    task automatic t_pow_reset();
        fire(4'd0, 2'd0, 64'h80, 64'h40000);
        chk("R7 resume bit", srr_msr, 64'h10000);
        chk("R7 resume new msr", new_msr, HV | ME);
        fire(4'd0, 2'd0, 64'h6000, 0);
        chk("R7 plain reset saved", srr_msr, 0);
        chk("R7 plain reset new", new_msr, HV);
    endtask

    task automatic t_hv();
        fire(4'd9, 2'd0, 64'h5000, 64'h2);
        chk("R10 hv pair flag", 64'(enter_hv), 1);
        chk("R10 hsrr pc", hsrr_pc, 64'h5000);
        chk("R10 hsrr msr", hsrr_msr, 64'h2);
        chk("R10 new msr hv ri", new_msr, HV | 64'h2);
        chk("R10 srr untouched", srr_pc, 64'h6000);
        chk("R10 handler", handler_pc, 64'hA00);
    endtask

    task automatic t_reloc();
        reloc_mode = 2'd2;
        fire(4'd2, 2'd0, 64'h90, HV | 64'h30);
        chk("R9 mode2 handler", handler_pc, 64'h18300);
        chk("R9 mode2 new msr", new_msr, HV | 64'h30);
        reloc_mode = 2'd3;
        fire(4'd2, 2'd0, 64'h90, HV | 64'h30);
        chk("R9 mode3 handler", handler_pc, 64'hC000_0000_0000_4300);
        reloc_mode = 2'd2;
        fire(4'd9, 2'd0, 64'h90, 64'h30);
        chk("R9 entering hv no reloc", handler_pc, 64'hA00);
        chk("R9 entering hv new msr", new_msr, HV);
        fire(4'd9, 2'd0, 64'h90, HV | 64'h30);
        chk("R9 already hv reloc", handler_pc, 64'h18A00);
        fire(4'd0, 2'd0, 64'h90, 64'h30);
        chk("R9 reset no reloc", handler_pc, 64'h100);
        reloc_mode = 2'd3;
        fire(4'd2, 2'd0, 64'h90, 64'h20);
        chk("R9 one xlate bit no reloc", handler_pc, 64'h300);
        chk("R9 one xlate bit new msr", new_msr, 0);
        reloc_mode = 2'd1;
        fire(4'd2, 2'd0, 64'h90, 64'h30);
        chk("R9 mode1 no reloc", handler_pc, 64'h300);
        reloc_mode = 2'd0;
    endtask

    task automatic t_vector();
        vec_prefix = 64'hFFF0_0000;
        fire(4'd2, 2'd0, 64'hA0, 0);
        chk("R8 prefix", handler_pc, 64'hFFF0_0300);
        vec_prefix = 0;
        vec_table[6*64 +: 64] = '1;
        fire(4'd6, 2'd0, 64'hA0, 0);
        chk("R8 undefined vector stop", 64'(checkstop), 1);
        chk("R8 undefined no entry", 64'(enter_valid), 0);
        vec_table[6*64 +: 64] = 64'h700;
        do_reset();
        fire(4'd12, 2'd0, 64'hA0, 0);
        chk("R8 invalid code stop", 64'(checkstop), 1);
        do_reset();
    endtask

    task automatic t_rfi();
        fire(4'd2, 2'd0, 64'h1_2345_6787, 64'h8000_0000_0000_0020);
        ret(1'b0);
        chk("R11 ret valid", 64'(ret_valid), 1);
        chk("R11 ret pc 64", ret_pc, 64'h1_2345_6784);
        chk("R11 ret msr", ret_msr, 64'h8000_0000_0000_0020);
        fire(4'd2, 2'd0, 64'h1_2345_6787, 64'h20);
        impl_mask = ~64'h20;
        ret(1'b0);
        chk("R11 ret pc 32", ret_pc, 64'h2345_6784);
        chk("R11 ret msr masked", ret_msr, 0);
        impl_mask = '1;
        fire(4'd9, 2'd0, 64'h7002, 0);
        ret(1'b1);
        chk("R11 ret hv pair pc", ret_pc, 64'h7000);
    endtask

    task automatic t_collide();
        @(negedge clk);
        exc_code = 4'd2; exc_sub = 0; cur_pc = 64'h8000; cur_msr = 0;
        exc_valid = 1'b1; rfi_req = 1'b1; rfi_hv = 1'b0;
        @(posedge clk); #1;
        exc_valid = 1'b0; rfi_req = 1'b0;
        chk("R12 exception wins enter", 64'(enter_valid), 1);
        chk("R12 exception wins ret", 64'(ret_valid), 0);
        chk("R12 exception wins srr", srr_pc, 64'h8000);
    endtask

    initial begin
        for (int i = 0; i < 10; i++) vec_table[i*64 +: 64] = 64'(i + 1) * 64'h100;
        do_reset();
        t_reset();
        t_basic();
        t_program();
        t_fp_drop();
        t_mcheck();
        t_wake();
        t_pow_reset();
        t_hv();
        t_reloc();
        t_vector();
        t_rfi();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule